// File: doc/BRIEF.md
# Flash Program/Erase Setup Register Bank

This block is a small register bank on a byte-wide bus with an address, a write strobe, write data and combinational read data. It holds the control state that a flash macro needs before it may program or erase: a software write-enable flag, program-setup and erase-setup bits, program and erase bits, two verify bits and an 8-bit erase block select. Every write passes through interlocks. Setup bits need the write-enable flag. Program and erase need their setup bits. A single write may raise at most one control bit. The block select takes only one-hot values.

Two inputs, low-power and flash-disable, are sampled on the clock. Either one clears all state and blocks writes. Flash-disable also blanks every read to 0x00. A third input, the top-block lock, keeps the highest block out of reach while it is high. The program-setup, erase-setup, program, erase and block-select outputs go directly to the flash macro.

Top module: `flash_pe_regs`

## Requirements
- R1: After reset every register reads 0x00 and every output to the flash macro is 0. The control register is at address 0. Its bits are: bit 7 write-enable, bit 6 erase-setup, bit 5 program-setup, bit 4 erase-verify, bit 3 program-verify, bit 2 erase, bit 1 program, and bit 0 always reads 0.
- R2: The program-setup and erase-setup bits become 1 only while the stored write-enable bit is 1. Otherwise a write of 1 to them is ignored.
- R3: The program bit becomes or stays 1 only while program-setup is 1 before and after the write. The erase bit follows the same rule with erase-setup. The prog_o and erase_o outputs follow these bits.
- R4: A control write that would change more than one control bit from 0 to 1 is rejected as a whole, and the register keeps its old value.
- R5: When write-enable is 0 after a write, every other control bit is 0. The block select is 0x00 one cycle after write-enable is 0.
- R6: The block select is at address 2 and is written only while write-enable is 1. A value with at most one bit set is stored. A value with two or more bits set is dropped, and the old value is kept.
- R7: Address 1 (the upper block register) and address 3 always read 0x00, and writes to them change nothing.
- R8: While top_blk_lock_i is high, bit 7 of written block-select data is treated as 0 before the one-hot check. A stored bit 7 clears one clock after the lock rises.
- R9: A high lowpwr_i is sampled on one clock. On the next clock all registers clear, and writes are ignored for as long as the sampled level stays high.
- R10: A high flash_off_i is sampled on one clock. From then on reads return 0x00, writes are ignored, and all registers clear on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| lowpwr_i | input | 1 | Low-power mode request |
| flash_off_i | input | 1 | Flash disabled |
| top_blk_lock_i | input | 1 | Protects the highest block bit |
| prog_setup_o | output | 1 | Program setup to flash macro |
| erase_setup_o | output | 1 | Erase setup to flash macro |
| prog_o | output | 1 | Program bit to flash macro |
| erase_o | output | 1 | Erase bit to flash macro |
| blk_sel_o | output | 8 | One-hot erase block select |

## Verification
A wrong interlock shows on the cycle after the offending write. The read-back of address 0 or 2 then differs from the reference value, and a setup, program or block output rises without its precondition. A missed clear shows two clocks after lowpwr_i or flash_off_i rises, as nonzero read data or a nonzero block select. The bench walks a table of legal and illegal writes and compares each read-back at once. It then drives the mode inputs, the lock and reset directly and checks the ports at those exact cycles.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;
  localparam int DW     = 8;
  localparam int AW     = 2;
  localparam int TOPBIT = DW - 1;

  localparam logic [AW-1:0] A_CTL    = 2'd0;
  localparam logic [AW-1:0] A_BLK_HI = 2'd1;
  localparam logic [AW-1:0] A_BLK    = 2'd2;

  // control register, MSB first
  typedef struct packed {
    logic wen;
    logic esu;
    logic psu;
    logic evf;
    logic pvf;
    logic ers;
    logic prg;
    logic rsvd;
  } ctl_t;

  localparam logic [DW-1:0] CTL_LIVE = 8'hFE;
endpackage

// File: rtl/flash_pe_sync.sv
module flash_pe_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_an,
  input  logic [N-1:0] raw_i,
  output logic         rst_sn,
  output logic [N-1:0] samp_o
);
  logic [1:0] rs_q;

  always_ff @(posedge clk or negedge rst_an) begin
    if (!rst_an) rs_q <= '0;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  for (genvar i = 0; i < N; i++) begin : g_samp
    logic s_q;
    always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn) s_q <= 1'b0;
      else         s_q <= raw_i[i];
    end
    assign samp_o[i] = s_q;
  end
endmodule

// File: rtl/flash_pe_ctl.sv
module flash_pe_ctl
  import flash_pe_pkg::*;
(
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          clr_i,
  output ctl_t          ctl_o
);
  ctl_t          ctl_q, ctl_d, req;
  logic [DW-1:0] rise;
  logic          reject, ctl_en;

  always_comb begin
    req    = ctl_t'(wdata_i & CTL_LIVE);
    rise   = (wdata_i & CTL_LIVE) & ~ctl_q;
    reject = ($countones(rise) > 1);
    ctl_d  = '0;
    ctl_en = 1'b0;
    if (clr_i) begin
      ctl_en = 1'b1;
    end else if (wr_i && !reject) begin
      ctl_en    = 1'b1;
      ctl_d.wen = req.wen;
      ctl_d.psu = req.psu & ctl_q.wen;
      ctl_d.esu = req.esu & ctl_q.wen;
      ctl_d.pvf = req.pvf & ctl_q.wen;
      ctl_d.evf = req.evf & ctl_q.wen;
      ctl_d.prg = req.prg & ctl_q.psu & ctl_d.psu;
      ctl_d.ers = req.ers & ctl_q.esu & ctl_d.esu;
      if (!ctl_d.wen) ctl_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     ctl_q <= '0;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/flash_pe_blk.sv
module flash_pe_blk
  import flash_pe_pkg::*;
(
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wen_i,
  input  logic          clr_i,
  input  logic          lock_i,
  output logic [DW-1:0] blk_o
);
  localparam logic [DW-1:0] TOP_M = 1 << TOPBIT;

  logic [DW-1:0] blk_q, blk_d, masked;
  logic          legal, blk_en;

  always_comb begin
    masked = lock_i ? (wdata_i & ~TOP_M) : wdata_i;
    legal  = ($countones(masked) <= 1);
    blk_d  = blk_q;
    blk_en = 1'b0;
    if (clr_i || !wen_i) begin
      blk_d  = '0;
      blk_en = 1'b1;
    end else if (wr_i && legal) begin
      blk_d  = masked;
      blk_en = 1'b1;
    end else if (lock_i && blk_q[TOPBIT]) begin
      blk_d  = blk_q & ~TOP_M;
      blk_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     blk_q <= '0;
    else if (blk_en) blk_q <= blk_d;
  end

  assign blk_o = blk_q;
endmodule

// File: rtl/flash_pe_rdmux.sv
module flash_pe_rdmux
  import flash_pe_pkg::*;
(
  input  logic [AW-1:0] addr_i,
  input  ctl_t          ctl_i,
  input  logic [DW-1:0] blk_i,
  input  logic          blank_i,
  output logic [DW-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (!blank_i) begin
      unique case (addr_i)
        A_CTL:    rdata_o = ctl_i & CTL_LIVE;
        A_BLK:    rdata_o = blk_i;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/flash_pe_regs.sv
module flash_pe_regs
  import flash_pe_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          lowpwr_i,
  input  logic          flash_off_i,
  input  logic          top_blk_lock_i,
  output logic          prog_setup_o,
  output logic          erase_setup_o,
  output logic          prog_o,
  output logic          erase_o,
  output logic [DW-1:0] blk_sel_o
);
  logic          rst_s, lp_q, off_q, hold;
  logic [1:0]    samp;
  ctl_t          ctl;
  logic          wen_q;
  logic [DW-1:0] ctl_byte;
  logic          wr_ctl, wr_blk;

  flash_pe_sync #(.N(2)) u_sync (
    .clk    (clk),
    .rst_an (rst_n),
    .raw_i  ({flash_off_i, lowpwr_i}),
    .rst_sn (rst_s),
    .samp_o (samp)
  );
  assign lp_q  = samp[0];
  assign off_q = samp[1];
  assign hold  = lp_q | off_q;

  assign wr_ctl = bus_we && (bus_addr == A_CTL) && !hold;
  assign wr_blk = bus_we && (bus_addr == A_BLK) && !hold;

  flash_pe_ctl u_ctl (
    .clk     (clk),
    .rst_sn  (rst_s),
    .wr_i    (wr_ctl),
    .wdata_i (bus_wdata),
    .clr_i   (hold),
    .ctl_o   (ctl)
  );
  assign wen_q    = ctl.wen;
  assign ctl_byte = ctl;

  flash_pe_blk u_blk (
    .clk     (clk),
    .rst_sn  (rst_s),
    .wr_i    (wr_blk),
    .wdata_i (bus_wdata),
    .wen_i   (wen_q),
    .clr_i   (hold),
    .lock_i  (top_blk_lock_i),
    .blk_o   (blk_sel_o)
  );

  flash_pe_rdmux u_rd (
    .addr_i  (bus_addr),
    .ctl_i   (ctl),
    .blk_i   (blk_sel_o),
    .blank_i (off_q),
    .rdata_o (bus_rdata)
  );

  assign prog_setup_o  = ctl.psu;
  assign erase_setup_o = ctl.esu;
  assign prog_o        = ctl.prg;
  assign erase_o       = ctl.ers;
endmodule

// File: rtl/flash_pe_chk.sv
module flash_pe_chk (
  input logic       clk,
  input logic       rst_s,
  input logic       lp_q,
  input logic       off_q,
  input logic       wen_q,
  input logic [7:0] ctl_byte,
  input logic [1:0] bus_addr,
  input logic       bus_we,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       top_blk_lock_i,
  input logic       prog_setup_o,
  input logic       erase_setup_o,
  input logic       prog_o,
  input logic       erase_o,
  input logic [7:0] blk_sel_o
);
  p_psu_rise_r2: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(prog_setup_o) |-> $past(wen_q));
  p_esu_rise_r2: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(erase_setup_o) |-> $past(wen_q));
  p_prog_setup_r3: assert property (@(posedge clk) disable iff (!rst_s)
    prog_o |-> prog_setup_o);
  p_erase_setup_r3: assert property (@(posedge clk) disable iff (!rst_s)
    erase_o |-> erase_setup_o);
  p_multi_rise_r4: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_we && bus_addr == 2'd0 && !lp_q && !off_q &&
     $countones(bus_wdata & 8'hFE & ~ctl_byte) > 1) |=> $stable(ctl_byte));
  p_wen_gate_r5: assert property (@(posedge clk) disable iff (!rst_s)
    !wen_q |-> (ctl_byte == 8'h00));
  p_blk_drop_r5: assert property (@(posedge clk) disable iff (!rst_s)
    !wen_q |=> (blk_sel_o == 8'h00));
  p_blk_onehot_r6: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(blk_sel_o));
  p_hi_zero_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_addr == 2'd1 || bus_addr == 2'd3) |-> (bus_rdata == 8'h00));
  p_top_lock_r8: assert property (@(posedge clk) disable iff (!rst_s)
    $past(top_blk_lock_i) |-> !blk_sel_o[7]);
  p_lp_clear_r9: assert property (@(posedge clk) disable iff (!rst_s)
    lp_q |=> (ctl_byte == 8'h00 && blk_sel_o == 8'h00));
  p_off_blank_r10: assert property (@(posedge clk) disable iff (!rst_s)
    off_q |-> (bus_rdata == 8'h00));
endmodule

bind flash_pe_regs flash_pe_chk u_chk (
  .clk            (clk),
  .rst_s          (rst_s),
  .lp_q           (lp_q),
  .off_q          (off_q),
  .wen_q          (wen_q),
  .ctl_byte       (ctl_byte),
  .bus_addr       (bus_addr),
  .bus_we         (bus_we),
  .bus_wdata      (bus_wdata),
  .bus_rdata      (bus_rdata),
  .top_blk_lock_i (top_blk_lock_i),
  .prog_setup_o   (prog_setup_o),
  .erase_setup_o  (erase_setup_o),
  .prog_o         (prog_o),
  .erase_o        (erase_o),
  .blk_sel_o      (blk_sel_o)
);

// File: tb/sim_flash_pe_regs.sv
`timescale 1ns/1ps
module sim_flash_pe_regs;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_we;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       lowpwr_i, flash_off_i, top_blk_lock_i;
  logic       prog_setup_o, erase_setup_o, prog_o, erase_o;
  logic [7:0] blk_sel_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  flash_pe_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lowpwr_i(lowpwr_i),
    .flash_off_i(flash_off_i), .top_blk_lock_i(top_blk_lock_i),
    .prog_setup_o(prog_setup_o), .erase_setup_o(erase_setup_o),
    .prog_o(prog_o), .erase_o(erase_o), .blk_sel_o(blk_sel_o)
  );

  // vector: {we, addr, wdata, expected read-back of addr, requirement number}
  localparam int NV = 21;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 2'd0, 8'h20, 8'h00, 4'd2},  // R2 psetup without wen
    {1'b1, 2'd2, 8'h01, 8'h00, 4'd6},  // R6 block write without wen
    {1'b1, 2'd0, 8'h80, 8'h80, 4'd1},  // R1 set wen
    {1'b1, 2'd0, 8'hA2, 8'h80, 4'd4},  // R4 two rising bits
    {1'b1, 2'd0, 8'h82, 8'h80, 4'd3},  // R3 program without psetup
    {1'b1, 2'd0, 8'hA0, 8'hA0, 4'd2},  // R2 psetup with wen
    {1'b1, 2'd0, 8'hA2, 8'hA2, 4'd3},  // R3 program after psetup
    {1'b1, 2'd2, 8'h03, 8'h00, 4'd6},  // R6 two bits dropped
    {1'b1, 2'd2, 8'h10, 8'h10, 4'd6},  // R6 one-hot accepted
    {1'b1, 2'd2, 8'h00, 8'h00, 4'd6},  // R6 zero accepted
    {1'b1, 2'd2, 8'h80, 8'h80, 4'd6},  // R6 top bit unlocked
    {1'b1, 2'd2, 8'h81, 8'h80, 4'd6},  // R6 keeps old value
    {1'b1, 2'd1, 8'hFF, 8'h00, 4'd7},  // R7 upper block register
    {1'b1, 2'd0, 8'h80, 8'h80, 4'd3},  // R3 falling bits only
    {1'b1, 2'd0, 8'hC0, 8'hC0, 4'd2},  // R2 esetup with wen
    {1'b1, 2'd0, 8'hC4, 8'hC4, 4'd3},  // R3 erase after esetup
    {1'b1, 2'd0, 8'h84, 8'h80, 4'd3},  // R3 erase dropped with esetup
    {1'b1, 2'd0, 8'h98, 8'h80, 4'd4},  // R4 both verify bits
    {1'b1, 2'd0, 8'h88, 8'h88, 4'd4},  // R4 single verify bit
    {1'b1, 2'd0, 8'h00, 8'h00, 4'd5},  // R5 wen cleared
    {1'b0, 2'd2, 8'h00, 8'h00, 4'd5}   // R5 block cleared after wen drop
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    bus_addr = a;
    #1;
    check(bus_rdata, exp, req);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    lowpwr_i = 1'b0; flash_off_i = 1'b0; top_blk_lock_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) rd(a[1:0], 8'h00, "R1");
    check({prog_setup_o, erase_setup_o, prog_o, erase_o}, 8'h00, "R1");
    check(blk_sel_o, 8'h00, "R1");

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = VEC[i];
      if (v[22]) wr(v[21:20], v[19:12]);
      else @(negedge clk);
      rd(v[21:20], v[11:4], $sformatf("R%0d vec%0d", v[3:0], i));
    end

    // R3 outputs toward the flash macro
    wr(2'd0, 8'h80); wr(2'd0, 8'hA0); wr(2'd0, 8'hA2);
    check({7'd0, prog_setup_o}, 8'h01, "R3 psetup out");
    check({7'd0, prog_o}, 8'h01, "R3 prog out");
    check({7'd0, erase_o}, 8'h00, "R3 erase out");

    // R9 low-power clear and write block
    wr(2'd0, 8'h80); wr(2'd2, 8'h04);
    check(blk_sel_o, 8'h04, "R9 pre");
    @(negedge clk); lowpwr_i = 1'b1;
    repeat (2) @(negedge clk);
    rd(2'd0, 8'h00, "R9 ctl cleared");
    check(blk_sel_o, 8'h00, "R9 blk cleared");
    wr(2'd0, 8'h80);
    rd(2'd0, 8'h00, "R9 write ignored");
    lowpwr_i = 1'b0;
    repeat (2) @(negedge clk);

    // R10 flash disabled
    wr(2'd0, 8'h80); wr(2'd2, 8'h02);
    @(negedge clk); flash_off_i = 1'b1;
    @(negedge clk);
    rd(2'd2, 8'h00, "R10 read blanked");
    @(negedge clk);
    check(blk_sel_o, 8'h00, "R10 blk cleared");
    wr(2'd0, 8'h80);
    flash_off_i = 1'b0;
    repeat (2) @(negedge clk);
    rd(2'd0, 8'h00, "R10 write ignored");

    // R8 top-block lock
    wr(2'd0, 8'h80);
    top_blk_lock_i = 1'b1;
    wr(2'd2, 8'h81);
    rd(2'd2, 8'h01, "R8 masked one-hot");
    wr(2'd2, 8'h80);
    rd(2'd2, 8'h00, "R8 masked to zero");
    top_blk_lock_i = 1'b0;
    wr(2'd2, 8'h80);
    rd(2'd2, 8'h80, "R8 unlocked top");
    top_blk_lock_i = 1'b1;
    @(negedge clk);
    rd(2'd2, 8'h00, "R8 top cleared by lock");
    top_blk_lock_i = 1'b0;

    // R1 asynchronous reset mid-operation
    wr(2'd2, 8'h08);
    rst_n = 1'b0;
    #1;
    rd(2'd0, 8'h00, "R1 reset ctl");
    check(blk_sel_o, 8'h00, "R1 reset blk");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(2'd2, 8'h00, "R1 after reset");

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end
endmodule